// File: doc/BRIEF.md
# Flash Byte Program and Sector Erase Engine

This block is a device-side model of a small parallel flash array that has an embedded program and erase engine. The host starts an operation by presenting a command for one cycle on a synchronous command port. The command can be a byte program, a sector erase, a whole-array erase, or a reset that clears a failure. The engine then runs for a fixed number of clock cycles. While it runs, the `busy` output is high. At the end of a successful operation the array is updated.

While an operation is in flight, a read of an address that the operation covers returns a polling status byte instead of the array contents. Bit 7 of that byte tells the host when the operation has finished. Bit 5 reports a failure. A failure can come from a program that would need a 0 cell to turn back into a 1, or from an internal timeout. After a failure the engine holds its status until the host sends the reset command.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset every byte of the array reads 8'hFF, and `busy` and `err` are 0.
- R2: A byte program (cmd_op 2'b00) accepted while idle keeps `busy` high for exactly PROG_CYC cycles. At the end, the byte holds the bitwise AND of its old value and the command data.
- R3: While a program runs, a read of its target address returns the status byte {~data[7], 1'b0, err, 5'b00000}. Reads of other addresses return stored data.
- R4: Once an operation completes without failure, reads of the touched addresses return the stored bytes, so bit 7 equals the programmed bit 7.
- R5: A program whose data has a 1 where the addressed byte holds a 0 fails on the next cycle. `err` and `busy` go high, the byte is not changed, and the target reads {~data[7], 1'b0, 1'b1, 5'b0}.
- R6: A sector erase (cmd_op 2'b01) keeps `busy` high for ERASE_CYC cycles and then sets every byte of the addressed sector to 8'hFF. Other sectors are left unchanged. While it runs, reads inside that sector return 8'h00 (bit 7 at 0, bit 5 at 0).
- R7: A whole-array erase (cmd_op 2'b10) keeps `busy` high for CHIP_CYC cycles and then sets every byte to 8'hFF. While it runs, every address reads as status.
- R8: If an operation needs more cycles than TIMEOUT_CYC, it stops after TIMEOUT_CYC busy cycles with `err` high and the array unchanged. Reads in its range then show bit 5 set.
- R9: After a failure, `busy`, `err` and the status reads hold until a reset command (cmd_op 2'b11). The cycle after the reset command, `busy` and `err` are 0 and reads return array data.
- R10: A command presented while `busy` is high has no effect. This includes a reset during a running operation and any command other than reset during a failure.
- R11: A reset command while idle has no effect on the array or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 00 program, 01 sector erase, 10 whole-array erase, 11 reset |
| cmd_addr | input | ADDR_W | Target byte address; its upper bits select the sector |
| cmd_data | input | 8 | Byte to program |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte, or polling status during an operation |
| busy | output | 1 | High while an operation runs or a failure is held |
| err | output | 1 | Failure flag |

## Verification
The bench uses several program patterns. Legal patterns with target bit 7 at 0 and at 1 show whether the polling bit really inverts the intended bit rather than the stored bit. A repeat program that only clears bits confirms the AND rule. A pattern that would set a cleared bit separates the immediate error path from the timed path. The erases are checked both inside and outside the selected sector, which separates per-sector status from whole-array status. A second instance with a short timeout limit shows that an overlong erase ends in a held failure rather than an update of the array.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

   typedef enum logic [1:0] {
      OP_PROG   = 2'b00,
      OP_SERASE = 2'b01,
      OP_CERASE = 2'b10,
      OP_RESET  = 2'b11
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_SERASE,
      ST_CERASE,
      ST_FAIL
   } state_e;

   typedef enum logic [1:0] {
      JOB_PROG,
      JOB_SERASE,
      JOB_CERASE
   } job_e;

   localparam int BYTE_W = 8;

   // status byte: poll bit in 7, failure in 5, rest zero
   function automatic logic [BYTE_W-1:0] status_word(input logic poll_bit, input logic fail_bit);
      return {poll_bit, 1'b0, fail_bit, 5'b00000};
   endfunction

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   input  logic [CNT_W-1:0] tmo_lim,
   output logic             done,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (start)  cnt <= '0;
      else if (run)    cnt <= cnt + 1'b1;
   end

   // completion wins over timeout when both land on the same cycle
   always_comb begin
      done    = run && (cnt == limit - 1'b1);
      expired = run && !done && (cnt == tmo_lim - 1'b1);
   end

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
   import flash_pe_pkg::*;
#(
   parameter int SECTORS      = 4,
   parameter int SECTOR_BYTES = 16,
   parameter int ADDR_W       = 6,
   parameter int OFF_W        = 4,
   parameter int SEC_W        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [BYTE_W-1:0] prog_data,
   input  logic              erase_sec_en,
   input  logic [SEC_W-1:0]  erase_sec,
   input  logic              erase_all,
   input  logic [ADDR_W-1:0] rd_a_addr,
   output logic [BYTE_W-1:0] rd_a_q,
   input  logic [ADDR_W-1:0] rd_b_addr,
   output logic [BYTE_W-1:0] rd_b_q
);

   localparam int TOTAL = SECTORS * SECTOR_BYTES;

   logic [TOTAL*BYTE_W-1:0] flat;

   for (genvar s = 0; s < SECTORS; s++) begin : g_sec
      logic [BYTE_W-1:0] bank [SECTOR_BYTES];
      logic              hit_erase;
      logic              hit_prog;

      always_comb begin
         hit_erase = erase_all || (erase_sec_en && (erase_sec == SEC_W'(s)));
         hit_prog  = prog_en && (prog_addr[ADDR_W-1:OFF_W] == SEC_W'(s));
      end

      always_ff @(posedge clk) begin
         if (!rst_n || hit_erase) begin
            for (int b = 0; b < SECTOR_BYTES; b++) bank[b] <= '1;
         end else if (hit_prog) begin
            bank[prog_addr[OFF_W-1:0]] <= bank[prog_addr[OFF_W-1:0]] & prog_data;
         end
      end

      for (genvar b = 0; b < SECTOR_BYTES; b++) begin : g_byte
         assign flat[(s*SECTOR_BYTES + b)*BYTE_W +: BYTE_W] = bank[b];
      end
   end

   always_comb begin
      rd_a_q = flat[rd_a_addr*BYTE_W +: BYTE_W];
      rd_b_q = flat[rd_b_addr*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
   import flash_pe_pkg::*;
#(
   parameter int ADDR_W        = 6,
   parameter int OFF_W         = 4,
   parameter int SEC_W         = 2,
   parameter int CNT_W         = 8,
   parameter int PROG_CYC      = 4,
   parameter int ERASE_CYC     = 12,
   parameter int CHIP_CYC      = 30,
   parameter int TIMEOUT_CYC   = 40,
   parameter bit CHIP_ERASE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [BYTE_W-1:0] cmd_data,
   input  logic [BYTE_W-1:0] cell_q,
   input  logic              tmr_done,
   input  logic              tmr_expired,
   output state_e            st,
   output job_e              job,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [BYTE_W-1:0] tgt_data,
   output logic              fail,
   output logic              tmr_start,
   output logic              tmr_run,
   output logic [CNT_W-1:0]  tmr_limit,
   output logic [CNT_W-1:0]  tmr_tmo,
   output logic              arr_prog,
   output logic              arr_serase,
   output logic [SEC_W-1:0]  arr_sec,
   output logic              arr_cerase
);

   op_e  op;
   logic chip_ok;
   logic idle_cmd;
   logic raise_bits;

   if (CHIP_ERASE_EN) begin : g_chip_on
      assign chip_ok = 1'b1;
   end else begin : g_chip_off
      assign chip_ok = 1'b0;
   end

   always_comb begin
      op         = op_e'(cmd_op);
      idle_cmd   = cmd_vld && (st == ST_IDLE);
      raise_bits = |(cmd_data & ~cell_q);
      tmr_run    = (st == ST_PROG) || (st == ST_SERASE) || (st == ST_CERASE);
      tmr_start  = idle_cmd && (op != OP_RESET);
      tmr_tmo    = CNT_W'(TIMEOUT_CYC);
      unique case (st)
         ST_SERASE: tmr_limit = CNT_W'(ERASE_CYC);
         ST_CERASE: tmr_limit = CNT_W'(CHIP_CYC);
         default:   tmr_limit = CNT_W'(PROG_CYC);
      endcase
      arr_prog   = (st == ST_PROG)   && tmr_done;
      arr_serase = (st == ST_SERASE) && tmr_done;
      arr_cerase = (st == ST_CERASE) && tmr_done;
      arr_sec    = tgt_addr[ADDR_W-1:OFF_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         job      <= JOB_PROG;
         tgt_addr <= '0;
         tgt_data <= '1;
         fail     <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (idle_cmd) begin
                  unique case (op)
                     OP_PROG: begin
                        job      <= JOB_PROG;
                        tgt_addr <= cmd_addr;
                        tgt_data <= cmd_data;
                        if (raise_bits) begin
                           st   <= ST_FAIL;
                           fail <= 1'b1;
                        end else begin
                           st <= ST_PROG;
                        end
                     end
                     OP_SERASE: begin
                        job      <= JOB_SERASE;
                        tgt_addr <= cmd_addr;
                        st       <= ST_SERASE;
                     end
                     OP_CERASE: begin
                        if (chip_ok) begin
                           job      <= JOB_CERASE;
                           tgt_addr <= cmd_addr;
                           st       <= ST_CERASE;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            ST_PROG, ST_SERASE, ST_CERASE: begin
               if (tmr_done) begin
                  st <= ST_IDLE;
               end else if (tmr_expired) begin
                  st   <= ST_FAIL;
                  fail <= 1'b1;
               end
            end
            ST_FAIL: begin
               if (cmd_vld && (op == OP_RESET)) begin
                  st   <= ST_IDLE;
                  fail <= 1'b0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
   import flash_pe_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int OFF_W  = 4
) (
   input  state_e            st,
   input  job_e              job,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              tgt_bit7,
   input  logic              fail,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [BYTE_W-1:0] cell_rd,
   output logic [BYTE_W-1:0] rd_data
);

   logic hit;
   logic poll;

   always_comb begin
      unique case (job)
         JOB_PROG:   hit = (rd_addr == tgt_addr);
         JOB_SERASE: hit = (rd_addr[ADDR_W-1:OFF_W] == tgt_addr[ADDR_W-1:OFF_W]);
         default:    hit = 1'b1;
      endcase
      poll = (job == JOB_PROG) ? ~tgt_bit7 : 1'b0;
      if ((st != ST_IDLE) && hit) rd_data = status_word(poll, fail);
      else                        rd_data = cell_rd;
   end

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
   import flash_pe_pkg::*;
#(
   parameter int SECTORS       = 4,
   parameter int SECTOR_BYTES  = 16,
   parameter int PROG_CYC      = 4,
   parameter int ERASE_CYC     = 12,
   parameter int CHIP_CYC      = 30,
   parameter int TIMEOUT_CYC   = 40,
   parameter bit CHIP_ERASE_EN = 1'b1,
   localparam int SEC_W        = $clog2(SECTORS),
   localparam int OFF_W        = $clog2(SECTOR_BYTES),
   localparam int ADDR_W       = SEC_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              err
);

   localparam int MAX_CYC = (TIMEOUT_CYC > CHIP_CYC) ?
                            ((TIMEOUT_CYC > ERASE_CYC) ? TIMEOUT_CYC : ERASE_CYC) :
                            ((CHIP_CYC > ERASE_CYC) ? CHIP_CYC : ERASE_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC + PROG_CYC + 1) + 1;

   if (SECTORS < 2 || (SECTORS & (SECTORS - 1)) != 0) begin : g_bad_sectors
      $error("SECTORS must be a power of two of at least 2");
   end
   if (SECTOR_BYTES < 2 || (SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("SECTOR_BYTES must be a power of two of at least 2");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1 || CHIP_CYC < 1 || TIMEOUT_CYC < 1) begin : g_bad_cyc
      $error("cycle counts must be at least 1");
   end

   state_e            st;
   job_e              job;
   logic [ADDR_W-1:0] tgt_addr;
   logic [BYTE_W-1:0] tgt_data;
   logic              fail;
   logic              tmr_start;
   logic              tmr_run;
   logic [CNT_W-1:0]  tmr_limit;
   logic [CNT_W-1:0]  tmr_tmo;
   logic              tmr_done;
   logic              tmr_expired;
   logic              arr_prog;
   logic              arr_serase;
   logic [SEC_W-1:0]  arr_sec;
   logic              arr_cerase;
   logic [BYTE_W-1:0] cell_cmd;
   logic [BYTE_W-1:0] cell_rd;

   flash_pe_ctrl #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEC_W(SEC_W), .CNT_W(CNT_W),
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CHIP_CYC(CHIP_CYC),
      .TIMEOUT_CYC(TIMEOUT_CYC), .CHIP_ERASE_EN(CHIP_ERASE_EN)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .cell_q(cell_cmd), .tmr_done(tmr_done), .tmr_expired(tmr_expired),
      .st(st), .job(job), .tgt_addr(tgt_addr), .tgt_data(tgt_data), .fail(fail),
      .tmr_start(tmr_start), .tmr_run(tmr_run), .tmr_limit(tmr_limit), .tmr_tmo(tmr_tmo),
      .arr_prog(arr_prog), .arr_serase(arr_serase), .arr_sec(arr_sec), .arr_cerase(arr_cerase)
   );

   flash_op_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .run(tmr_run),
      .limit(tmr_limit), .tmo_lim(tmr_tmo), .done(tmr_done), .expired(tmr_expired)
   );

   flash_cell_array #(
      .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES),
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEC_W(SEC_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .prog_en(arr_prog), .prog_addr(tgt_addr), .prog_data(tgt_data),
      .erase_sec_en(arr_serase), .erase_sec(arr_sec), .erase_all(arr_cerase),
      .rd_a_addr(cmd_addr), .rd_a_q(cell_cmd),
      .rd_b_addr(rd_addr), .rd_b_q(cell_rd)
   );

   flash_status_mux #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_status (
      .st(st), .job(job), .tgt_addr(tgt_addr), .tgt_bit7(tgt_data[7]), .fail(fail),
      .rd_addr(rd_addr), .cell_rd(cell_rd), .rd_data(rd_data)
   );

   always_comb begin
      busy = (st != ST_IDLE);
      err  = fail;
   end

endmodule

// File: rtl/flash_pe_checker.sv
module flash_pe_checker
   import flash_pe_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int OFF_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_vld,
   input logic [1:0]        cmd_op,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [7:0]        rd_data,
   input logic              busy,
   input logic              err,
   input state_e            st,
   input job_e              job,
   input logic [ADDR_W-1:0] tgt_addr,
   input logic [7:0]        tgt_data
);

   a_r5_err_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> busy);

   a_r9_err_held: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(cmd_vld && cmd_op == 2'b11)) |=> err);

   a_r9_reset_leaves_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (err && cmd_vld && cmd_op == 2'b11) |=> (!busy && !err));

   a_r2_program_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_vld && cmd_op == 2'b00) |=> busy);

   a_r11_idle_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_vld && cmd_op == 2'b11) |=> (!busy && !err));

   a_r3_poll_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && job == JOB_PROG && rd_addr == tgt_addr) |-> (rd_data[7] != tgt_data[7]));

   a_r6_erase_status: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SERASE && rd_addr[ADDR_W-1:OFF_W] == tgt_addr[ADDR_W-1:OFF_W])
      |-> (rd_data == 8'h00));

endmodule

bind flash_pe_engine flash_pe_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
   .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .err(err),
   .st(st), .job(job), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
);

// File: tb/flash_pe_engine_bench.sv
`timescale 1ns/1ps
module flash_pe_engine_bench;

   localparam int P  = 4;
   localparam int E  = 12;
   localparam int C  = 30;
   localparam int AW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          a_vld = 0, b_vld = 0;
   logic [1:0]    a_op = 0, b_op = 0;
   logic [AW-1:0] a_addr = 0, b_addr = 0, a_raddr = 0, b_raddr = 0;
   logic [7:0]    a_data = 0, b_data = 0, a_rdata, b_rdata;
   logic          a_busy, a_err, b_busy, b_err;

   int n_run = 0;
   int n_fail = 0;

   flash_pe_engine u_flash_pe_engine (
      .clk(clk), .rst_n(rst_n), .cmd_vld(a_vld), .cmd_op(a_op), .cmd_addr(a_addr),
      .cmd_data(a_data), .rd_addr(a_raddr), .rd_data(a_rdata), .busy(a_busy), .err(a_err));

   flash_pe_engine #(.TIMEOUT_CYC(8)) u_tmo (
      .clk(clk), .rst_n(rst_n), .cmd_vld(b_vld), .cmd_op(b_op), .cmd_addr(b_addr),
      .cmd_data(b_data), .rd_addr(b_raddr), .rd_data(b_rdata), .busy(b_busy), .err(b_err));

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmd(input bit inst, input logic [1:0] op, input int addr, input logic [7:0] d);
      @(negedge clk);
      if (!inst) begin a_vld = 1; a_op = op; a_addr = AW'(addr); a_data = d; end
      else       begin b_vld = 1; b_op = op; b_addr = AW'(addr); b_data = d; end
      @(negedge clk);
      a_vld = 0; b_vld = 0;
      #1;
   endtask

   task automatic rd(input bit inst, input int addr, output logic [7:0] q);
      if (!inst) begin a_raddr = AW'(addr); #0.5; q = a_rdata; end
      else       begin b_raddr = AW'(addr); #0.5; q = b_rdata; end
   endtask

   // counts the negedges with busy high, starting at the current one
   task automatic busy_len(output int n);
      n = 0;
      while (a_busy && n < 1000) begin n++; @(negedge clk); #1; end
   endtask

   task automatic t_reset;
      logic [7:0] q;
      chk("R1 busy", a_busy, 0);
      chk("R1 err", a_err, 0);
      for (int i = 0; i < 64; i += 21) begin rd(0, i, q); chk("R1 erased", q, 8'hFF); end
   endtask

   task automatic t_program;
      logic [7:0] q; int n;
      cmd(0, 2'b00, 3, 8'h5A);
      rd(0, 3, q); chk("R3 poll bit7 low target", q, 8'h80);
      rd(0, 4, q); chk("R3 other addr data", q, 8'hFF);
      busy_len(n); chk("R2 program length", n + 1 - 1, P);
      rd(0, 3, q); chk("R4 stored 5A", q, 8'h5A);
      cmd(0, 2'b00, 3, 8'h12);
      busy_len(n);
      rd(0, 3, q); chk("R2 AND result", q, 8'h12);
      cmd(0, 2'b00, 5, 8'h80);
      rd(0, 5, q); chk("R3 poll bit7 high target", q, 8'h00);
      busy_len(n);
      rd(0, 5, q); chk("R4 stored 80", q, 8'h80);
   endtask

   task automatic t_illegal;
      logic [7:0] q;
      cmd(0, 2'b00, 3, 8'h13);
      chk("R5 err", a_err, 1);
      chk("R5 busy", a_busy, 1);
      rd(0, 3, q); chk("R5 status", q, 8'hA0);
      repeat (5) @(negedge clk);
      #1;
      chk("R9 err held", a_err, 1);
      cmd(0, 2'b01, 3, 8'h00);
      chk("R10 erase ignored in fail", a_err, 1);
      cmd(0, 2'b11, 0, 8'h00);
      chk("R9 busy cleared", a_busy, 0);
      chk("R9 err cleared", a_err, 0);
      rd(0, 3, q); chk("R5 byte unchanged", q, 8'h12);
   endtask

   task automatic t_busy_ignore;
      logic [7:0] q; int n;
      cmd(0, 2'b00, 20, 8'hF0);
      cmd(0, 2'b00, 21, 8'h00);
      cmd(0, 2'b11, 0, 8'h00);
      busy_len(n);
      chk("R10 run not aborted", a_err, 0);
      rd(0, 21, q); chk("R10 second program ignored", q, 8'hFF);
      rd(0, 20, q); chk("R10 first program done", q, 8'hF0);
   endtask

   task automatic t_sector_erase;
      logic [7:0] q; int n;
      cmd(0, 2'b01, 7, 8'h00);
      rd(0, 3, q);  chk("R6 status in sector", q, 8'h00);
      rd(0, 20, q); chk("R6 data outside sector", q, 8'hF0);
      busy_len(n); chk("R6 erase length", n, E);
      rd(0, 3, q);  chk("R6 erased 3", q, 8'hFF);
      rd(0, 5, q);  chk("R6 erased 5", q, 8'hFF);
      rd(0, 20, q); chk("R6 other sector kept", q, 8'hF0);
   endtask

   task automatic t_chip_erase;
      logic [7:0] q; int n;
      cmd(0, 2'b00, 40, 8'h00);
      busy_len(n);
      cmd(0, 2'b10, 0, 8'h00);
      rd(0, 40, q); chk("R7 status addr 40", q, 8'h00);
      rd(0, 20, q); chk("R7 status addr 20", q, 8'h00);
      busy_len(n); chk("R7 chip length", n, C);
      rd(0, 40, q); chk("R7 erased 40", q, 8'hFF);
      rd(0, 20, q); chk("R7 erased 20", q, 8'hFF);
   endtask

   task automatic t_idle_reset;
      logic [7:0] q; int n;
      cmd(0, 2'b00, 10, 8'h33);
      busy_len(n);
      cmd(0, 2'b11, 10, 8'h00);
      chk("R11 busy stays low", a_busy, 0);
      chk("R11 err stays low", a_err, 0);
      rd(0, 10, q); chk("R11 data kept", q, 8'h33);
   endtask

   task automatic t_timeout;
      logic [7:0] q;
      cmd(1, 2'b00, 2, 8'h0F);
      repeat (P) @(negedge clk);
      #1;
      cmd(1, 2'b01, 0, 8'h00);
      rd(1, 2, q); chk("R8 erase status before timeout", q, 8'h00);
      repeat (7) @(negedge clk);
      #1;
      chk("R8 no err before limit", b_err, 0);
      @(negedge clk); #1;
      chk("R8 err at limit", b_err, 1);
      chk("R8 busy held", b_busy, 1);
      rd(1, 2, q); chk("R8 status bit5", q, 8'h20);
      cmd(1, 2'b11, 0, 8'h00);
      chk("R9 tmo cleared", b_busy, 0);
      rd(1, 2, q); chk("R8 array unchanged", q, 8'h0F);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_program();
      t_illegal();
      t_busy_ignore();
      t_sector_erase();
      t_chip_erase();
      t_idle_reset();
      t_timeout();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule